// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block is the destination-address filter on the receive side of an Ethernet MAC. The address arrives one byte per cycle on a small stream input. A start marker flags the first byte of each frame. Once the sixth byte has been taken, the block gives a single-cycle decision strobe with an accept/drop flag. Three rules feed that flag:

- An individual address must match a programmed 48-bit station address exactly.
- A group address is looked up in a 512-entry single-bit hash table.
- The all-ones broadcast address and promiscuous mode always pass.

The hash bucket comes from a CRC-32 that the block computes byte by byte while the address streams in. The CRC is the reflected form, seeded with all ones and with no final inversion. The 32-bit result is bit-reversed and its nine most significant bits form the bucket. Software edits the table one bucket at a time through a control word that carries a 9-bit index and a set/clear bit.

A narrow write-only configuration port reaches four words, selected by a 2-bit select:

| Select | Word |
|---|---|
| 0 | Station low |
| 1 | Station high |
| 2 | Mode |
| 3 | Hash control |

Top module: `mac_rx_addr_filter`

## Requirements
- R1: Select 0 loads station bits [31:0] and select 1 loads station bits [47:32] from data [15:0]. Station byte k (wire order, k=0 first) sits in bits [8k+7:8k], and the same packing applies to the received address. An individual address (bit 0 of byte 0 clear) is accepted only when all 48 bits equal the station address.
- R2: A group address (bit 0 of byte 0 set) is decided by the hash table alone and is never compared with the station address.
- R3: The bucket is bits [31:23] of the bit-reversed value of a reflected CRC-32 computed over the six bytes in wire order. The CRC uses polynomial 0x04C11DB7 (0xEDB88320 in reflected form), an all-ones seed and no final inversion.
- R4: A write to select 3 uses data [8:0] as the bucket index. Data bit 9 set makes that bucket accept and bit 9 clear makes it reject. No other bucket changes.
- R5: After reset every hash bucket rejects.
- R6: With mode bit 0 (promiscuous) set, every frame is accepted.
- R7: The destination FF:FF:FF:FF:FF:FF is always accepted.
- R8: `dec_valid` is high for exactly one cycle, in the cycle after the clock edge that takes the sixth byte. `dec_accept` is low whenever `dec_valid` is low.
- R9: Cycles with `rx_valid` low do not advance the byte position. Bytes without a start marker are ignored, both after reset and after the sixth byte, and produce no strobe.
- R10: A byte with `rx_sof` set always becomes byte 0 of a new address, even when a previous address is only partly received.
- R11: Reset clears the outputs, the station address (to zero) and the promiscuous bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_sel | input | 2 | Word select: 0 station low, 1 station high, 2 mode, 3 hash control |
| cfg_wr_data | input | 32 | Configuration write data |
| rx_valid | input | 1 | Address byte valid |
| rx_sof | input | 1 | Marks the first address byte of a frame |
| rx_byte | input | 8 | Address byte, wire order |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Frame accepted; meaningful only with dec_valid |

## Verification
The assertions compare the decision with the station address and promiscuous bit as they stand in the strobe cycle. They therefore assume neither register is written on the edge that takes the sixth byte or the one before the strobe is seen. The stimulus performs every configuration write with no address in flight, between frames. The assertions also assume every frame is framed by a start marker. The bench drives one, except in the deliberate stray-byte and restart tests, where only the strobe properties are exercised.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

    localparam int ADDR_BYTES  = 6;
    localparam int ADDR_W      = 8 * ADDR_BYTES;
    localparam int HASH_IDX_W  = 9;
    localparam int HASH_SET_BIT = HASH_IDX_W;
    localparam int CFG_DW      = 32;
    localparam int CFG_SEL_W   = 2;
    localparam int CRC_W       = 32;

    localparam logic [CRC_W-1:0] CRC_POLY_LSB = 32'hEDB8_8320;
    localparam logic [CRC_W-1:0] CRC_SEED     = 32'hFFFF_FFFF;

    typedef enum logic [CFG_SEL_W-1:0] {
        SEL_STA_LO = 2'd0,
        SEL_STA_HI = 2'd1,
        SEL_MODE   = 2'd2,
        SEL_HASH   = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic                  wr;
        logic                  set;
        logic [HASH_IDX_W-1:0] idx;
    } hash_cmd_t;

    typedef struct packed {
        logic              last;
        logic [ADDR_W-1:0] addr;
        logic [CRC_W-1:0]  crc;
    } addr_view_t;

    // One byte of the LSB-first CRC, bit 0 of the byte first.
    function automatic logic [CRC_W-1:0] crc_step_byte(input logic [CRC_W-1:0] c,
                                                        input logic [7:0] b);
        logic [CRC_W-1:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ b[i])
                r = (r >> 1) ^ CRC_POLY_LSB;
            else
                r = r >> 1;
        end
        return r;
    endfunction

    // Reverse the CRC and keep its top index bits.
    function automatic logic [HASH_IDX_W-1:0] crc_to_bucket(input logic [CRC_W-1:0] c);
        logic [CRC_W-1:0] rev;
        for (int i = 0; i < CRC_W; i++)
            rev[i] = c[CRC_W-1-i];
        return rev[CRC_W-1 -: HASH_IDX_W];
    endfunction

endpackage

// File: rtl/mhf_cfg_regs.sv
module mhf_cfg_regs
    import mhf_pkg::*;
#(
    parameter int DW = CFG_DW,
    parameter int SW = CFG_SEL_W,
    parameter int AW = ADDR_W,
    parameter int IW = HASH_IDX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_sel,
    input  logic [DW-1:0] wr_data,
    output logic [AW-1:0] station,
    output logic          promisc,
    output hash_cmd_t     hash_cmd
);

    localparam int LO_W = DW;
    localparam int HI_W = AW - DW;

    cfg_sel_e sel;
    assign sel = cfg_sel_e'(wr_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            station <= '0;
            promisc <= 1'b0;
        end else if (wr_en) begin
            case (sel)
                SEL_STA_LO: station[LO_W-1:0]  <= wr_data;
                SEL_STA_HI: station[AW-1:LO_W] <= wr_data[HI_W-1:0];
                SEL_MODE:   promisc            <= wr_data[0];
                default:    ;
            endcase
        end
    end

    always_comb begin
        hash_cmd.wr  = wr_en && (sel == SEL_HASH);
        hash_cmd.set = wr_data[HASH_SET_BIT];
        hash_cmd.idx = wr_data[IW-1:0];
    end

endmodule

// File: rtl/mhf_addr_collect.sv
module mhf_addr_collect
    import mhf_pkg::*;
#(
    parameter int N_BYTES = ADDR_BYTES,
    parameter int AW      = 8 * N_BYTES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rx_valid,
    input  logic          rx_sof,
    input  logic [7:0]    rx_byte,
    output addr_view_t    view,
    output logic [AW-1:0] frame_addr
);

    localparam int CNT_W = $clog2(N_BYTES + 1);
    localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(N_BYTES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(N_BYTES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] pos;
    logic [CRC_W-1:0] crc_q;
    logic [AW-1:0]    addr_q;
    logic             take;
    logic [AW-1:0]    addr_nx;
    logic [CRC_W-1:0] crc_nx;

    always_comb begin
        pos     = rx_sof ? '0 : cnt_q;
        take    = rx_valid && (rx_sof || (cnt_q != CNT_DONE));
        crc_nx  = crc_step_byte(rx_sof ? CRC_SEED : crc_q, rx_byte);
        addr_nx = rx_sof ? '0 : addr_q;
        for (int k = 0; k < N_BYTES; k++) begin
            if (pos == CNT_W'(k))
                addr_nx[8*k +: 8] = rx_byte;
        end
    end

    // Counter rests at N_BYTES: stray bytes wait for a start marker.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= CNT_DONE;
            crc_q  <= CRC_SEED;
            addr_q <= '0;
        end else if (take) begin
            cnt_q  <= pos + 1'b1;
            crc_q  <= crc_nx;
            addr_q <= addr_nx;
        end
    end

    assign view.last  = take && (pos == CNT_LAST);
    assign view.addr  = addr_nx;
    assign view.crc   = crc_nx;
    assign frame_addr = addr_q;

endmodule

// File: rtl/mhf_hash_table.sv
module mhf_hash_table
    import mhf_pkg::*;
#(
    parameter int IW = HASH_IDX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          wr_set,
    input  logic [IW-1:0] wr_idx,
    input  logic [IW-1:0] rd_idx,
    output logic          rd_hit
);

    localparam int ENTRIES = 1 << IW;

    logic [ENTRIES-1:0] bucket_q;

    always_ff @(posedge clk) begin
        if (rst)
            bucket_q <= '0;
        else if (wr_en)
            bucket_q[wr_idx] <= wr_set;
    end

    // Lookup sees the table as it stood before a same-edge write.
    assign rd_hit = bucket_q[rd_idx];

endmodule

// File: rtl/mac_rx_addr_filter.sv
module mac_rx_addr_filter
    import mhf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_wr_en,
    input  logic [CFG_SEL_W-1:0] cfg_wr_sel,
    input  logic [CFG_DW-1:0]    cfg_wr_data,
    input  logic                 rx_valid,
    input  logic                 rx_sof,
    input  logic [7:0]           rx_byte,
    output logic                 dec_valid,
    output logic                 dec_accept
);

    logic [ADDR_W-1:0]     station_q;
    logic                  promisc_q;
    hash_cmd_t             hash_cmd;
    addr_view_t            view;
    logic [ADDR_W-1:0]     frame_addr;
    logic [HASH_IDX_W-1:0] bucket;
    logic                  bucket_hit;
    logic                  is_group;
    logic                  is_bcast;
    logic                  is_station;
    logic                  accept_now;

    mhf_cfg_regs #(
        .DW (CFG_DW),
        .SW (CFG_SEL_W),
        .AW (ADDR_W),
        .IW (HASH_IDX_W)
    ) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_wr_en),
        .wr_sel   (cfg_wr_sel),
        .wr_data  (cfg_wr_data),
        .station  (station_q),
        .promisc  (promisc_q),
        .hash_cmd (hash_cmd)
    );

    mhf_addr_collect #(
        .N_BYTES (ADDR_BYTES),
        .AW      (ADDR_W)
    ) u_col (
        .clk        (clk),
        .rst        (rst),
        .rx_valid   (rx_valid),
        .rx_sof     (rx_sof),
        .rx_byte    (rx_byte),
        .view       (view),
        .frame_addr (frame_addr)
    );

    assign bucket = crc_to_bucket(view.crc);

    mhf_hash_table #(
        .IW (HASH_IDX_W)
    ) u_tab (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (hash_cmd.wr),
        .wr_set (hash_cmd.set),
        .wr_idx (hash_cmd.idx),
        .rd_idx (bucket),
        .rd_hit (bucket_hit)
    );

    always_comb begin
        is_group   = view.addr[0];
        is_bcast   = &view.addr;
        is_station = (view.addr == station_q);
        accept_now = promisc_q || is_bcast ||
                     (is_group ? bucket_hit : is_station);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
        end else begin
            dec_valid  <= view.last;
            dec_accept <= view.last && accept_now;
        end
    end

endmodule

// File: rtl/mhf_filter_chk.sv
module mhf_filter_chk
    import mhf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              rx_valid,
    input logic              dec_valid,
    input logic              dec_accept,
    input logic [ADDR_W-1:0] frame_addr,
    input logic [ADDR_W-1:0] station,
    input logic              promisc
);

    // R8
    dec_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        dec_valid |=> !dec_valid);

    // R8
    accept_qual_chk: assert property (@(posedge clk) disable iff (rst)
        !dec_valid |-> !dec_accept);

    // R9
    strobe_cause_chk: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> $past(rx_valid));

    // R6
    promisc_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && promisc) |-> dec_accept);

    // R7
    bcast_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && (&frame_addr)) |-> dec_accept);

    // R1
    ucast_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !frame_addr[0] && frame_addr == station) |-> dec_accept);

    // R1
    ucast_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !promisc && !frame_addr[0] && frame_addr != station)
            |-> !dec_accept);

endmodule

bind mac_rx_addr_filter mhf_filter_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .rx_valid   (rx_valid),
    .dec_valid  (dec_valid),
    .dec_accept (dec_accept),
    .frame_addr (frame_addr),
    .station    (station_q),
    .promisc    (promisc_q)
);

// File: tb/mac_rx_addr_filter_tb.sv
module mac_rx_addr_filter_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic [1:0]  cfg_wr_sel = '0;
    logic [31:0] cfg_wr_data = '0;
    logic        rx_valid = 1'b0;
    logic        rx_sof = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        dec_valid;
    logic        dec_accept;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    mac_rx_addr_filter u_dut (
        .clk         (clk),
        .rst         (rst),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_sel  (cfg_wr_sel),
        .cfg_wr_data (cfg_wr_data),
        .rx_valid    (rx_valid),
        .rx_sof      (rx_sof),
        .rx_byte     (rx_byte),
        .dec_valid   (dec_valid),
        .dec_accept  (dec_accept)
    );

    // op: 0 none, 1 set own bucket, 2 clear own bucket, 3 set neighbour bucket
    typedef struct packed {
        logic [47:0] da;
        logic [1:0]  op;
        logic        promisc;
        logic        exp;
    } vec_t;

    localparam logic [47:0] STA  = 48'h5544_3322_1102;
    localparam logic [47:0] GRPA = 48'h0100_005E_0001;
    localparam logic [47:0] GRPB = 48'h0100_0000_3333;
    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{STA,                 2'd0, 1'b0, 1'b1},
        '{48'h5644_3322_1102,  2'd0, 1'b0, 1'b0},
        '{48'h5544_3322_1106,  2'd0, 1'b0, 1'b0},
        '{GRPA,                2'd0, 1'b0, 1'b0},
        '{GRPA,                2'd1, 1'b0, 1'b1},
        '{GRPB,                2'd2, 1'b0, 1'b0},
        '{GRPA,                2'd2, 1'b0, 1'b0},
        '{GRPB,                2'd3, 1'b0, 1'b0},
        '{48'hFFFF_FFFF_FFFF,  2'd0, 1'b0, 1'b1},
        '{48'h0000_000A_0B00,  2'd0, 1'b1, 1'b1},
        '{GRPB,                2'd0, 1'b1, 1'b1},
        '{48'hAABB_CCDD_EE00,  2'd0, 1'b0, 1'b0}
    };

    // Bench-side bucket: bitwise reflected CRC, then index from reversed top bits.
    function automatic logic [8:0] ref_bucket(input logic [47:0] a);
        logic [31:0] c;
        logic [8:0]  b;
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < 48; i++) begin
            logic fb;
            fb = c[0] ^ a[i];
            c = c >> 1;
            if (fb) c = c ^ 32'hEDB8_8320;
        end
        for (int k = 0; k < 9; k++) b[8-k] = c[k];
        return b;
    endfunction

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic chk(input logic act, input logic exp, input string req, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data);
        cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = data;
        @(negedge clk);
        cfg_wr_en = 1'b0; cfg_wr_data = '0;
        @(negedge clk);
    endtask

    task automatic send_frame(input logic [47:0] da, input int gap);
        for (int i = 0; i < 6; i++) begin
            rx_valid = 1'b1; rx_sof = (i == 0); rx_byte = da[8*i +: 8];
            @(negedge clk);
            rx_valid = 1'b0; rx_sof = 1'b0;
            if (i < 5) begin
                for (int g = 0; g < gap; g++) begin
                    chk(dec_valid, 1'b0, "R9", "no strobe mid-address");
                    @(negedge clk);
                end
            end
        end
    endtask

    task automatic expect_dec(input logic exp, input string req);
        chk(dec_valid, 1'b1, "R8", "strobe after sixth byte");
        chk(dec_accept, exp, req, "decision");
        @(negedge clk);
        chk(dec_valid, 1'b0, "R8", "strobe lasts one cycle");
        chk(dec_accept, 1'b0, "R8", "accept low without strobe");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(dec_valid, 1'b0, "R11", "valid after reset");
        chk(dec_accept, 1'b0, "R11", "accept after reset");

        // R9 stray bytes with no start marker
        for (int i = 0; i < 7; i++) begin
            rx_valid = 1'b1; rx_sof = 1'b0; rx_byte = 8'(i);
            @(negedge clk);
            chk(dec_valid, 1'b0, "R9", "stray byte after reset");
        end
        rx_valid = 1'b0;
        @(negedge clk);

        // R11 station resets to zero
        send_frame(48'h0, 0);
        expect_dec(1'b1, "R11");
        // R5 table empty after reset
        send_frame(GRPA, 0);
        expect_dec(1'b0, "R5");

        // R1 program station
        cfg_write(2'd0, STA[31:0]);
        cfg_write(2'd1, {16'h0, STA[47:32]});

        // Vector walk: R1 R2 R3 R4 R6 R7
        foreach (VECS[v]) begin
            logic [8:0] b;
            b = ref_bucket(VECS[v].da);
            cfg_write(2'd2, {31'h0, VECS[v].promisc});
            case (VECS[v].op)
                2'd1: cfg_write(2'd3, {22'h0, 1'b1, b});
                2'd2: cfg_write(2'd3, {22'h0, 1'b0, b});
                2'd3: cfg_write(2'd3, {22'h0, 1'b1, b ^ 9'd1});
                default: ;
            endcase
            send_frame(VECS[v].da, 0);
            expect_dec(VECS[v].exp, VECS[v].promisc ? "R6" :
                       (&VECS[v].da) ? "R7" :
                       VECS[v].da[0] ? "R3/R4" : "R1");
        end

        // R9 idle cycles between bytes do not advance
        send_frame(STA, 2);
        expect_dec(1'b1, "R9");
        // R9 bytes after the sixth are ignored
        for (int i = 0; i < 4; i++) begin
            rx_valid = 1'b1; rx_sof = 1'b0; rx_byte = 8'hA5;
            @(negedge clk);
            chk(dec_valid, 1'b0, "R9", "byte after sixth");
        end
        rx_valid = 1'b0;
        @(negedge clk);

        // R10 start marker restarts a partial address
        for (int i = 0; i < 3; i++) begin
            rx_valid = 1'b1; rx_sof = (i == 0); rx_byte = 8'hEE;
            @(negedge clk);
        end
        send_frame(STA, 0);
        expect_dec(1'b1, "R10");

        // R2 group station address is not compared
        cfg_write(2'd0, 32'h3322_1103);
        cfg_write(2'd3, {22'h0, 1'b0, ref_bucket(48'h5544_3322_1103)});
        send_frame(48'h5544_3322_1103, 0);
        expect_dec(1'b0, "R2");
        cfg_write(2'd3, {22'h0, 1'b1, ref_bucket(48'h5544_3322_1103)});
        send_frame(48'h5544_3322_1103, 1);
        expect_dec(1'b1, "R2");

        // R1 high word alone moves the station
        cfg_write(2'd0, 32'h3322_1102);
        cfg_write(2'd1, 32'h0000_7766);
        send_frame(STA, 0);
        expect_dec(1'b0, "R1");
        send_frame(48'h7766_3322_1102, 0);
        expect_dec(1'b1, "R1");

        finish_run();
    end

endmodule